// File: doc/BRIEF.md
# Prioritised Host Segment Mapper

This block translates accesses in a 16-bit host address space into byte addresses in a much larger external memory. It holds eight programmable segments. Each one has a 24-bit external page base, a one-byte host start page and a one-byte span measured in 256-byte pages. For every host lookup the block searches the segments in fixed order, from segment 0 to segment 7. The first segment whose page range covers the address produces the result. The result is a hit flag and an external byte address that is shifted up by 1 MB, so that the reserved low megabyte of external memory can never be reached.

A 256-bit input carries a per-page read-only mask. Any host page flagged in that mask never maps, even when a segment covers it. Lookups enter on a valid/ready stream and leave through a one-deep registered valid/ready stream. A request is taken only when the output slot is empty or is being drained in the same cycle. While the consumer holds ready low, the pending result stays on the outputs unchanged. Segment registers are loaded through a plain write port. A write becomes visible to lookups accepted from the following clock edge onward.

Top module: `seg_window_mapper`

## Requirements
- R1: After reset, out_valid is 0, host_ready is 1 and every segment has span 0, so every lookup misses.
- R2: A segment covers host address A when its span is nonzero, page(A)=A[15:8] is at least its start page, and page(A) minus start is less than span. Coverage never wraps past page 0xFF.
- R3: A segment whose span is 0 never hits.
- R4: When several segments cover an address, only the lowest-numbered one is used.
- R5: On a hit, out_addr = 0x100000 + base*256 + (A - start*256), 33 bits wide.
- R6: If rom_mask bit page(A) is 1, the lookup misses, whatever segments cover A.
- R7: A cfg write (cfg_field 0=external base from cfg_wdata[23:0], 1=start page from cfg_wdata[7:0], 2=span from cfg_wdata[7:0]) is seen by lookups accepted on later edges. A lookup accepted on the same edge as the write uses the old value.
- R8: host_ready is 0 exactly when out_valid is 1 and out_ready is 0. While out_ready is held low, out_valid, out_hit and out_addr do not change.
- R9: A cfg write with cfg_field 3 changes no segment.
- R10: When the result is a miss, out_addr is 0. When it is a hit, out_addr is at least 0x100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_seg | input | 3 | Segment index to write |
| cfg_field | input | 2 | 0 external base, 1 start page, 2 span, 3 none |
| cfg_wdata | input | 24 | Write data |
| rom_mask | input | 256 | Per-host-page read-only flag |
| host_valid | input | 1 | Lookup request valid |
| host_ready | output | 1 | Lookup request accepted when high with host_valid |
| host_addr | input | 16 | Host address to translate |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_hit | output | 1 | A segment mapped the address |
| out_addr | output | 33 | External byte address, 0 on miss |

## Verification
The interaction of interest is a segment register write and a lookup that are accepted on the same clock edge. The bench raises cfg_we and host_valid in the same cycle, with a new external base for segment 0 and an address inside that segment. It expects the result built from the old base. It then issues the same address again and expects the new base. A second overlap is between back-pressure and new requests: a request is offered while out_ready is low. The held result must stay unchanged and the request must be refused until the slot drains.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
  // Selects which register of a segment a configuration write targets.
  typedef enum logic [1:0] {
    FLD_EXT_BASE   = 2'd0,
    FLD_HOST_START = 2'd1,
    FLD_SPAN       = 2'd2,
    FLD_NONE       = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/hwm_seg_regs.sv
module hwm_seg_regs #(
  parameter int unsigned NSEG   = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned BASE_W = 24,
  parameter int unsigned PAGE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             seg,
  input  logic [1:0]                   field,
  input  logic [BASE_W-1:0]            wdata,
  output logic [NSEG-1:0][BASE_W-1:0]  base_q,
  output logic [NSEG-1:0][PAGE_W-1:0]  start_q,
  output logic [NSEG-1:0][PAGE_W-1:0]  span_q
);
  import hwm_pkg::*;

  cfg_field_e fld;
  assign fld = cfg_field_e'(field);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic sel;
    assign sel = we && (seg == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        start_q[g] <= '0;
        span_q[g]  <= '0;
      end else if (sel) begin
        case (fld)
          FLD_EXT_BASE:   base_q[g]  <= wdata;
          FLD_HOST_START: start_q[g] <= wdata[PAGE_W-1:0];
          FLD_SPAN:       span_q[g]  <= wdata[PAGE_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hwm_seg_match.sv
module hwm_seg_match #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned OFF_W       = 8,
  parameter int unsigned BASE_W      = 24,
  parameter int unsigned EXT_AW      = 33,
  parameter int unsigned RSVD_BYTES  = 32'h0010_0000,
  localparam int unsigned PAGE_W     = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic [PAGE_W-1:0] start,
  input  logic [PAGE_W-1:0] span,
  output logic              hit,
  output logic [EXT_AW-1:0] ext_addr
);
  logic [PAGE_W-1:0] page;
  logic [PAGE_W:0]   rel;
  logic [ADDR_W-1:0] offs;

  assign page = addr[ADDR_W-1:OFF_W];
  assign rel  = {1'b0, page} - {1'b0, start};
  assign hit  = (span != '0) && (page >= start) && (rel < {1'b0, span});
  assign offs = {rel[PAGE_W-1:0], addr[OFF_W-1:0]};

  assign ext_addr = EXT_AW'(RSVD_BYTES)
                  + EXT_AW'({base, {OFF_W{1'b0}}})
                  + EXT_AW'(offs);
endmodule

// File: rtl/hwm_prio_pick.sv
module hwm_prio_pick #(
  parameter int unsigned NSEG   = 8,
  parameter int unsigned EXT_AW = 33
) (
  input  logic [NSEG-1:0]              hits,
  input  logic [NSEG-1:0][EXT_AW-1:0]  addrs,
  output logic                         any_hit,
  output logic [EXT_AW-1:0]            addr
);
  // Walk from highest to lowest index so the lowest index assigns last.
  always_comb begin
    any_hit = 1'b0;
    addr    = '0;
    for (int i = NSEG - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        addr    = addrs[i];
      end
    end
  end
endmodule

// File: rtl/seg_window_mapper.sv
module seg_window_mapper #(
  parameter int unsigned NSEG       = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned BASE_W     = 24,
  parameter int unsigned RSVD_BYTES = 32'h0010_0000,
  localparam int unsigned IDX_W     = $clog2(NSEG),
  localparam int unsigned PAGE_W    = ADDR_W - OFF_W,
  localparam int unsigned NPAGES    = 1 << PAGE_W,
  localparam int unsigned EXT_AW    = BASE_W + OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_seg,
  input  logic [1:0]        cfg_field,
  input  logic [BASE_W-1:0] cfg_wdata,
  input  logic [NPAGES-1:0] rom_mask,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [EXT_AW-1:0] out_addr
);
  logic [NSEG-1:0][BASE_W-1:0] base_q;
  logic [NSEG-1:0][PAGE_W-1:0] start_q;
  logic [NSEG-1:0][PAGE_W-1:0] span_q;
  logic [NSEG-1:0]             seg_hit;
  logic [NSEG-1:0][EXT_AW-1:0] seg_addr;
  logic                        pick_hit;
  logic [EXT_AW-1:0]           pick_addr;
  logic                        in_rom;
  logic                        accept;

  hwm_seg_regs #(
    .NSEG(NSEG), .IDX_W(IDX_W), .BASE_W(BASE_W), .PAGE_W(PAGE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .seg(cfg_seg),
    .field(cfg_field), .wdata(cfg_wdata),
    .base_q(base_q), .start_q(start_q), .span_q(span_q)
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_match
    hwm_seg_match #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASE_W(BASE_W),
      .EXT_AW(EXT_AW), .RSVD_BYTES(RSVD_BYTES)
    ) u_match (
      .addr(host_addr), .base(base_q[g]), .start(start_q[g]),
      .span(span_q[g]), .hit(seg_hit[g]), .ext_addr(seg_addr[g])
    );
  end

  hwm_prio_pick #(.NSEG(NSEG), .EXT_AW(EXT_AW)) u_pick (
    .hits(seg_hit), .addrs(seg_addr), .any_hit(pick_hit), .addr(pick_addr)
  );

  assign in_rom     = rom_mask[host_addr[ADDR_W-1:OFF_W]];
  assign host_ready = !out_valid || out_ready;
  assign accept     = host_valid && host_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_addr  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_hit   <= pick_hit && !in_rom;
      out_addr  <= (pick_hit && !in_rom) ? pick_addr : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_window_mapper_chk.sv
module seg_window_mapper_chk #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned EXT_AW     = 33,
  parameter int unsigned RSVD_BYTES = 32'h0010_0000,
  localparam int unsigned NPAGES    = 1 << (ADDR_W - OFF_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPAGES-1:0] rom_mask,
  input logic              host_valid,
  input logic              host_ready,
  input logic [ADDR_W-1:0] host_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic [EXT_AW-1:0] out_addr
);
  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_addr)));

  assert_refuse_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !host_ready);

  assert_take_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready) |=> out_valid);

  assert_rom_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && rom_mask[host_addr[ADDR_W-1:OFF_W]]) |=> (out_valid && !out_hit));

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_addr == '0));

  assert_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (out_addr >= EXT_AW'(RSVD_BYTES)));
endmodule

bind seg_window_mapper seg_window_mapper_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .EXT_AW(EXT_AW), .RSVD_BYTES(RSVD_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rom_mask(rom_mask), .host_valid(host_valid),
  .host_ready(host_ready), .host_addr(host_addr), .out_valid(out_valid),
  .out_ready(out_ready), .out_hit(out_hit), .out_addr(out_addr)
);

// File: tb/tb_seg_window_mapper.sv
`timescale 1ns/1ps
module tb_seg_window_mapper;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_seg = '0;
  logic [1:0]   cfg_field = '0;
  logic [23:0]  cfg_wdata = '0;
  logic [255:0] rom_mask = '0;
  logic         host_valid = 1'b0;
  logic         host_ready;
  logic [15:0]  host_addr = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_hit;
  logic [32:0]  out_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_window_mapper dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .rom_mask(rom_mask),
    .host_valid(host_valid), .host_ready(host_ready), .host_addr(host_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_addr(out_addr)
  );

  // {host address, expected hit, expected external address}
  localparam logic [49:0] VEC [12] = '{
    {16'h4000, 1'b1, 33'h0_0010_1000},  // R2 R5 seg0 low edge
    {16'h4FFF, 1'b1, 33'h0_0010_1FFF},  // R2 seg0 top edge
    {16'h4823, 1'b1, 33'h0_0010_1823},  // R4 overlap, seg0 wins
    {16'h5000, 1'b1, 33'h0_0012_0800},  // R5 seg1
    {16'h67FF, 1'b1, 33'h0_0012_1FFF},  // R2 seg1 top edge
    {16'h6800, 1'b0, 33'h0},            // R2 past seg1
    {16'h3FFF, 1'b0, 33'h0},            // R2 below seg0
    {16'h8010, 1'b0, 33'h0},            // R3 span zero
    {16'hF000, 1'b1, 33'h0_0133_4500},  // R5 seg2
    {16'hFFFF, 1'b1, 33'h0_0133_54FF},  // R2 no wrap at top page
    {16'h00AB, 1'b1, 33'h1_000F_FFAB},  // R5 maximal base
    {16'h0100, 1'b0, 33'h0}             // R10 miss
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input int f, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 3'(s); cfg_field = 2'(f); cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    @(negedge clk);
    host_valid = 1'b1; host_addr = a;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1 host_ready after reset", 64'(host_ready), 64'd1);
    look(16'h4000);
    chk("R1 miss before config", 64'(out_hit), 64'd0);
    chk("R1 out_valid on result", 64'(out_valid), 64'd1);

    wr(0, 0, 24'h000010); wr(0, 1, 24'h40); wr(0, 2, 24'h10);
    wr(1, 0, 24'h000200); wr(1, 1, 24'h48); wr(1, 2, 24'h20);
    wr(2, 0, 24'h012345); wr(2, 1, 24'hF0); wr(2, 2, 24'h20);
    wr(3, 0, 24'h000005); wr(3, 1, 24'h80); wr(3, 2, 24'h00);
    wr(4, 0, 24'hFFFFFF); wr(4, 1, 24'h00); wr(4, 2, 24'h01);

    for (int i = 0; i < 12; i++) begin
      look(VEC[i][49:34]);
      chk("R2 R4 hit", 64'(out_hit), 64'(VEC[i][33]));
      chk("R5 R10 addr", 64'(out_addr), 64'(VEC[i][32:0]));
    end

    rom_mask[8'h41] = 1'b1;
    rom_mask[8'h50] = 1'b1;
    look(16'h4100);
    chk("R6 rom page seg0", 64'(out_hit), 64'd0);
    chk("R6 rom addr zero", 64'(out_addr), 64'd0);
    look(16'h5080);
    chk("R6 rom page seg1", 64'(out_hit), 64'd0);
    look(16'h4200);
    chk("R6 neighbour page", 64'(out_addr), 64'h101200);
    rom_mask = '0;

    // same-edge write and lookup
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 3'd0; cfg_field = 2'd0; cfg_wdata = 24'h000020;
    host_valid = 1'b1; host_addr = 16'h4000;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; host_valid = 1'b0;
    chk("R7 same-edge uses old base", 64'(out_addr), 64'h101000);
    look(16'h4000);
    chk("R7 next lookup sees new base", 64'(out_addr), 64'h102000);

    wr(0, 3, 24'h000001);
    look(16'h4F00);
    chk("R9 field 3 ignored hit", 64'(out_hit), 64'd1);
    chk("R9 field 3 ignored addr", 64'(out_addr), 64'h102F00);

    wr(1, 2, 24'h00);
    look(16'h5000);
    chk("R3 span cleared", 64'(out_hit), 64'd0);

    // back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    host_valid = 1'b1; host_addr = 16'hF010;
    @(posedge clk);
    @(negedge clk);
    host_addr = 16'h4000;
    chk("R8 ready low when full", 64'(host_ready), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 held valid", 64'(out_valid), 64'd1);
    chk("R8 held addr", 64'(out_addr), 64'h1334510);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    chk("R8 second accepted after drain", 64'(out_addr), 64'h102000);
    @(posedge clk);
    @(negedge clk);
    chk("R8 slot empties", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule